// File: doc/BRIEF.md
# LIN Remote Wake Detector

This block watches several sampled LIN bus levels, one bit for each channel, and decides when a remote node has asked the system to wake up. A wake is accepted only when the bus has stayed dominant for longer than a set number of clock cycles and then goes back to recessive. A level alone is never enough. After that return to recessive, the block waits a short settling delay. It then gives the mode controller a one-cycle wake pulse for that channel.

Each channel also keeps a sticky wake flag, so the controller can report afterwards which bus caused the wake. Detection runs only while the shared arm input is high. The mode controller holds arm high in sleep and during the filter window on the way from normal mode to sleep. A clear strobe drops all flags when normal mode is entered. The bus inputs must already be synchronised to the clock. The analog bus thresholds are outside this block.

Top module: `lin_wake_det`

## Requirements
- R1: After reset, every wake pulse and every wake flag is low.
- R2: Suppose a channel's dominant bit is sampled high on more than WAKE_CYC consecutive rising edges while armed, and the next edge samples it low. Then that channel's pulse is high for exactly one cycle. That cycle is the one that follows the STB_DLY-th rising edge after the edge that sampled the low level.
- R3: A dominant run of WAKE_CYC samples or fewer, followed by recessive, produces no pulse and sets no flag.
- R4: A qualifying dominant run that has not yet returned to recessive produces no pulse, however long it lasts.
- R5: A dominant run many times longer than WAKE_CYC still produces exactly one wake when it is released. The duration count saturates and never wraps.
- R6: While arm is low, dominant runs are not counted and no pulse occurs. Dropping arm during a count or during the settling delay abandons that wake.
- R7: A wake pulse never lasts more than one cycle.
- R8: A channel's flag goes high in the cycle after its pulse. It stays high until clr_i is sampled high or reset is applied. If clr_i is sampled high on the same edge that would set the flag, the flag stays low.
- R9: Bit i of bus_dom_i, wake_pulse_o and wake_flag_o belongs to channel i. Channels detect independently, in any combination.
- R10: Two short dominant runs separated by a recessive sample do not add together. Each run is timed from zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| arm_i | input | 1 | High while wake detection is permitted (sleep or sleep-entry window) |
| clr_i | input | 1 | Clears all sticky wake flags (normal-mode entry) |
| bus_dom_i | input | NCH | Synchronised bus level per channel, 1 = dominant |
| wake_pulse_o | output | NCH | One-cycle valid-wake pulse per channel |
| wake_flag_o | output | NCH | Sticky per-channel wake flag |

## Verification
The bench sweeps every dominant-run length from zero to twice the threshold. The off-by-one boundary at WAKE_CYC and WAKE_CYC+1 is where a design that tests "at least" instead of "longer than" would wake early. Every channel mask is tried, which catches channels that leak into each other or share a counter. Split dominant runs are used to catch a counter that is not cleared on recessive. Arm is dropped mid-count and mid-delay to catch a wake that survives a mode change. A clear placed on the exact setting edge exposes a wrong set/clear priority. The pulse cycle is checked against the exact settling delay, so a delay that is one cycle off is reported.

// File: rtl/lwk_pkg.sv
package lwk_pkg;
  typedef enum logic {
    DLY_IDLE = 1'b0,
    DLY_WAIT = 1'b1
  } dly_state_e;
endpackage

// File: rtl/lwk_dom_timer.sv
module lwk_dom_timer #(
  parameter int WAKE_CYC = 90
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic arm_i,
  input  logic dom_i,
  output logic release_o
);
  localparam int LIMIT = WAKE_CYC + 1;
  localparam int CW    = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          sat;
  logic          cnt_en;

  assign sat    = (cnt_q == CW'(LIMIT));
  assign cnt_en = arm_i & dom_i & ~sat;

  always_comb begin
    cnt_d = cnt_q;
    if (!(arm_i & dom_i)) begin
      cnt_d = '0;
    end else if (cnt_en) begin
      cnt_d = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign release_o = arm_i & ~dom_i & sat;

  // R5
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(LIMIT));

  // R6
  disarm_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !arm_i |=> (cnt_q == '0));

  // R10
  recessive_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dom_i |=> (cnt_q == '0));
endmodule

// File: rtl/lwk_stb_delay.sv
module lwk_stb_delay
  import lwk_pkg::*;
#(
  parameter int STB_DLY = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic arm_i,
  input  logic start_i,
  output logic pulse_o
);
  localparam int DW = (STB_DLY > 1) ? $clog2(STB_DLY) : 1;

  dly_state_e    st_q, st_d;
  logic [DW-1:0] dly_q, dly_d;
  logic          pulse_d;

  always_comb begin
    st_d    = st_q;
    dly_d   = dly_q;
    pulse_d = 1'b0;
    unique case (st_q)
      DLY_IDLE: begin
        if (start_i && arm_i) begin
          st_d  = DLY_WAIT;
          dly_d = DW'(STB_DLY - 1);
        end
      end
      DLY_WAIT: begin
        if (!arm_i) begin
          st_d = DLY_IDLE;
        end else if (dly_q == '0) begin
          st_d    = DLY_IDLE;
          pulse_d = 1'b1;
        end else begin
          dly_d = dly_q - DW'(1);
        end
      end
      default: st_d = DLY_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= DLY_IDLE;
      dly_q   <= '0;
      pulse_o <= 1'b0;
    end else begin
      st_q    <= st_d;
      dly_q   <= dly_d;
      pulse_o <= pulse_d;
    end
  end

  // R7
  single_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_o |=> !pulse_o);

  // R6
  disarm_no_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !arm_i |=> !pulse_o);
endmodule

// File: rtl/lwk_chan.sv
module lwk_chan #(
  parameter int WAKE_CYC = 90,
  parameter int STB_DLY  = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic arm_i,
  input  logic clr_i,
  input  logic dom_i,
  output logic pulse_o,
  output logic flag_o
);
  logic release_w;
  logic flag_d;

  lwk_dom_timer #(.WAKE_CYC(WAKE_CYC)) timer_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .arm_i    (arm_i),
    .dom_i    (dom_i),
    .release_o(release_w)
  );

  lwk_stb_delay #(.STB_DLY(STB_DLY)) delay_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .arm_i  (arm_i),
    .start_i(release_w),
    .pulse_o(pulse_o)
  );

  always_comb begin
    flag_d = flag_o;
    if (clr_i) begin
      flag_d = 1'b0;
    end else if (pulse_o) begin
      flag_d = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_o <= 1'b0;
    end else begin
      flag_o <= flag_d;
    end
  end

  // R8
  flag_source_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_o) |-> $past(pulse_o));

  // R8
  flag_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !flag_o);

  // R8
  flag_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_o && !clr_i) |=> flag_o);
endmodule

// File: rtl/lin_wake_det.sv
module lin_wake_det #(
  parameter int NCH      = 4,
  parameter int WAKE_CYC = 90,
  parameter int STB_DLY  = 3
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           arm_i,
  input  logic           clr_i,
  input  logic [NCH-1:0] bus_dom_i,
  output logic [NCH-1:0] wake_pulse_o,
  output logic [NCH-1:0] wake_flag_o
);
  for (genvar c = 0; c < NCH; c++) begin : g_ch
    lwk_chan #(.WAKE_CYC(WAKE_CYC), .STB_DLY(STB_DLY)) chan_i (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .arm_i  (arm_i),
      .clr_i  (clr_i),
      .dom_i  (bus_dom_i[c]),
      .pulse_o(wake_pulse_o[c]),
      .flag_o (wake_flag_o[c])
    );
  end

  initial begin
    // R2
    param_chk: assert (STB_DLY >= 1 && WAKE_CYC >= 1 && NCH >= 1);
  end
endmodule

// File: tb/lin_wake_det_tb_top.sv
`timescale 1ns/1ps
module lin_wake_det_tb_top;
  localparam int NCH = 4;
  localparam int W   = 4;
  localparam int D   = 3;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           arm = 1'b1;
  logic           clr = 1'b0;
  logic [NCH-1:0] dom = '0;
  logic [NCH-1:0] pulse;
  logic [NCH-1:0] flag;
  int n_run = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  lin_wake_det #(.NCH(NCH), .WAKE_CYC(W), .STB_DLY(D)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .arm_i(arm), .clr_i(clr),
    .bus_dom_i(dom), .wake_pulse_o(pulse), .wake_flag_o(flag)
  );

  task automatic chk(input string req, input logic [NCH-1:0] act, input logic [NCH-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic clear_flags();
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    chk("R8 clear", flag, '0);
  endtask

  // dominant on mask for len samples, release, watch the settling window
  task automatic run(input string req, input logic [NCH-1:0] mask, input int len);
    logic [NCH-1:0] want;
    want = (len > W) ? mask : '0;
    for (int i = 0; i < len; i++) begin
      dom = mask;
      @(negedge clk);
      chk({req, " R4 no pulse while dominant"}, pulse, '0);
    end
    dom = '0;
    for (int k = 1; k <= D + 3; k++) begin
      @(negedge clk);
      chk({req, " R2 pulse timing"}, pulse, (k == D + 1) ? want : '0);
    end
    chk({req, " R8 flag"}, flag, want);
    clear_flags();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 pulse reset", pulse, '0);
    chk("R1 flag reset", flag, '0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 R3: length sweep on every channel alone
    for (int c = 0; c < NCH; c++)
      for (int len = 0; len <= 2 * W; len++)
        run("R3 sweep", NCH'(1) << c, len);

    // R9: every channel combination, short and long
    for (int m = 0; m < (1 << NCH); m++) begin
      run("R9 mask long", NCH'(m), W + 2);
      run("R9 mask short", NCH'(m), W);
    end

    // R5: very long dominant period
    run("R5 long", 4'b0101, 20 * W);

    // R10: split runs do not accumulate
    for (int i = 0; i < W - 1; i++) begin dom = 4'b0010; @(negedge clk); end
    dom = '0; @(negedge clk);
    for (int i = 0; i < W - 1; i++) begin dom = 4'b0010; @(negedge clk); end
    dom = '0;
    for (int k = 0; k < D + 3; k++) begin @(negedge clk); chk("R10 split", pulse, '0); end
    chk("R10 split flag", flag, '0);

    // R6: disarmed throughout
    arm = 1'b0;
    for (int i = 0; i < W + 3; i++) begin dom = 4'b1111; @(negedge clk); end
    dom = '0;
    for (int k = 0; k < D + 3; k++) begin @(negedge clk); chk("R6 disarmed", pulse, '0); end
    arm = 1'b1;
    chk("R6 disarmed flag", flag, '0);

    // R6: arm dropped during settling delay
    for (int i = 0; i < W + 2; i++) begin dom = 4'b0001; @(negedge clk); end
    dom = '0; @(negedge clk);
    arm = 1'b0; @(negedge clk);
    arm = 1'b1;
    for (int k = 0; k < D + 3; k++) begin @(negedge clk); chk("R6 abort delay", pulse, '0); end
    chk("R6 abort delay flag", flag, '0);

    // R6: arm dropped mid-count restarts timing
    for (int i = 0; i < W - 1; i++) begin dom = 4'b1000; @(negedge clk); end
    arm = 1'b0; @(negedge clk);
    arm = 1'b1;
    for (int i = 0; i < W - 1; i++) @(negedge clk);
    dom = '0;
    for (int k = 0; k < D + 3; k++) begin @(negedge clk); chk("R6 abort count", pulse, '0); end

    // R8: clear on the setting edge wins, flag holds otherwise
    for (int i = 0; i < W + 1; i++) begin dom = 4'b0100; @(negedge clk); end
    dom = '0;
    for (int k = 1; k <= D + 1; k++) @(negedge clk);
    chk("R7 pulse present", pulse, 4'b0100);
    clr = 1'b1; @(negedge clk); clr = 1'b0;
    chk("R7 pulse one cycle", pulse, '0);
    chk("R8 clear wins", flag, '0);
    for (int i = 0; i < W + 1; i++) begin dom = 4'b0100; @(negedge clk); end
    dom = '0;
    repeat (D + 2 + 40) @(negedge clk);
    chk("R8 sticky", flag, 4'b0100);
    rst_n = 1'b0; @(negedge clk);
    chk("R1 reset clears flag", flag, '0);
    rst_n = 1'b1; @(negedge clk);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule